// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block watches a set of already-synchronized (or debounced) general-purpose input lines and raises an interrupt when a line meets its programmed trigger condition. Five conditions are available per line: rising edge, falling edge, either edge, high level and low level. Each line has an enable that gates detection and a mask that hides the line from the interrupt output without hiding it from the raw status.

Software reaches the block through a small word-addressed register port. It programs the trigger mode with three per-line bit vectors. It reads a raw status word to find which lines fired, even masked ones, and acknowledges edge events by writing ones to a clear word. Level-triggered lines need no acknowledge: their status bit tracks the pin for as long as the condition holds. One registered output carries the OR of all unmasked status bits to the interrupt controller.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the enable, mask, kind, dual and polarity words read 0, raw and pending status read 0, and `irq_out` is 0.
- R2: Words 0 (enable), 1 (mask), 2 (kind), 3 (dual), 4 (polarity) read back the last value written to them. Word 5 reads raw status, word 6 reads pending status, and word 7 (clear) reads 0.
- R3: A line whose enable bit is 0 never sets its raw status bit, and a disabled level line reads 0.
- R4: With kind=0, dual=0 and polarity=0, a 0-to-1 change of the line sets its raw bit at the clock edge that samples the new value. The bit stays set after the line returns to 0.
- R5: With kind=0, dual=0 and polarity=1, only a 1-to-0 change sets the raw bit. A 1-to-0 change is detected; a 0-to-1 change is not.
- R6: With kind=0 and dual=1, both a rising and a falling change set the raw bit, whatever the polarity bit holds.
- R7: With kind=1, the raw bit is 1 exactly while the line is high (polarity=0) or low (polarity=1). Writing the clear word does not clear it while the condition holds.
- R8: Writing word 7 clears each latched edge status bit whose data bit is 1. Bits written as 0 are left alone. Writing all ones clears every edge line.
- R9: Raw status ignores the mask. Pending status equals raw AND NOT mask.
- R10: `irq_out` is the OR of all pending bits, delayed by one register.
- R11: When a clear of a line and a new edge on that line fall in the same cycle, the new edge wins and the raw bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word index of the register accessed |
| reg_wdata | input | NLINES | Write data |
| reg_rdata | output | NLINES | Read data for `reg_addr` (combinational) |
| pin_in | input | NLINES | Synchronized or debounced line samples |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `pin_in` is already synchronous to `clk`. They assume that a single sample is the value the detector should act on, so no metastability or glitch handling is expected inside the block. They also assume software clears an edge line after changing its mode. The stimulus drives every pin and register value one time unit after a rising edge and changes each at most once per cycle. Mode changes are always followed by a clear before the affected line's status is checked.

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [NLINES-1:0] reg_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic              irq_out
);
  localparam logic [2:0] A_EN   = 3'd0;
  localparam logic [2:0] A_MSK  = 3'd1;
  localparam logic [2:0] A_KIND = 3'd2;
  localparam logic [2:0] A_DUAL = 3'd3;
  localparam logic [2:0] A_POL  = 3'd4;
  localparam logic [2:0] A_RAW  = 3'd5;
  localparam logic [2:0] A_PEND = 3'd6;
  localparam logic [2:0] A_ACK  = 3'd7;
  localparam logic [NLINES-1:0] ZERO = '0;

  logic [NLINES-1:0] en_r, msk_r, kind_r, dual_r, pol_r, raw_r, prev_r;
  logic [NLINES-1:0] rise, fall, edge_hit, lvl_hit, hit, ack, pend;

  assign rise     = pin_in & ~prev_r;
  assign fall     = ~pin_in & prev_r;
  assign edge_hit = (dual_r & (rise | fall)) | (~dual_r & pol_r & fall) | (~dual_r & ~pol_r & rise);
  assign lvl_hit  = pin_in ^ pol_r;
  assign hit      = en_r & ((kind_r & lvl_hit) | (~kind_r & edge_hit));
  assign ack      = (reg_we && reg_addr == A_ACK) ? reg_wdata : ZERO;
  assign pend     = raw_r & ~msk_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r   <= '0;
      msk_r  <= '0;
      kind_r <= '0;
      dual_r <= '0;
      pol_r  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_EN:    en_r   <= reg_wdata;
        A_MSK:   msk_r  <= reg_wdata;
        A_KIND:  kind_r <= reg_wdata;
        A_DUAL:  dual_r <= reg_wdata;
        A_POL:   pol_r  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_r   <= '0;
      prev_r  <= '0;
      irq_out <= 1'b0;
    end else begin
      raw_r   <= (kind_r & hit) | (~kind_r & ((raw_r & ~ack) | hit));
      prev_r  <= pin_in;
      irq_out <= |pend;
    end
  end

  always_comb begin
    case (reg_addr)
      A_EN:    reg_rdata = en_r;
      A_MSK:   reg_rdata = msk_r;
      A_KIND:  reg_rdata = kind_r;
      A_DUAL:  reg_rdata = dual_r;
      A_POL:   reg_rdata = pol_r;
      A_RAW:   reg_rdata = raw_r;
      A_PEND:  reg_rdata = pend;
      default: reg_rdata = ZERO;
    endcase
  end

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_r & ~$past(raw_r) & ~$past(en_r)) == ZERO)); // R3

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_ACK) |=> ((raw_r & $past(reg_wdata & ~en_r & ~kind_r)) == ZERO)); // R8

  AST_LEVEL_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_r & $past(kind_r & ~(pin_in ^ pol_r))) == ZERO)); // R7

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~raw_r & $past(kind_r & en_r & (pin_in ^ pol_r))) == ZERO)); // R7

  AST_IRQ_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|(raw_r & ~msk_r))); // R10

  AST_IRQ_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_r & ~msk_r)) |=> irq_out); // R10
endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] pin_in = '0;
  logic irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit           is_irq;
    logic [N-1:0] exp;
    string        req;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  gpio_irq_unit #(.NLINES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .irq_out(irq_out)
  );

  localparam logic [2:0] W_EN = 0, W_MSK = 1, W_KIND = 2, W_DUAL = 3, W_POL = 4, W_RAW = 5, W_PEND = 6, W_ACK = 7;

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [N-1:0] e, input string r);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string r);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = {{(N-1){1'b0}}, e}; it.req = r;
    q.push_back(it);
  endtask

  task automatic pins(input logic [N-1:0] v);
    @(posedge clk); #1;
    pin_in = v;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [N-1:0] act;
      it = q.pop_front();
      act = it.is_irq ? {{(N-1){1'b0}}, irq_out} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 7; i++) rd(3'(i), '0, "R1");
    chk_irq(1'b0, "R1");
    // R2 readback
    wr(W_KIND, 32'hF0F01234); rd(W_KIND, 32'hF0F01234, "R2"); wr(W_KIND, '0);
    wr(W_DUAL, 32'h0BAD0000); rd(W_DUAL, 32'h0BAD0000, "R2"); wr(W_DUAL, '0);
    wr(W_MSK, 32'h12345678); rd(W_MSK, 32'h12345678, "R2"); wr(W_MSK, '0);
    wr(W_POL, 32'h00C30000); rd(W_POL, 32'h00C30000, "R2"); wr(W_POL, '0);
    rd(W_ACK, '0, "R2");
    // R3 disabled line
    pins(32'h1); rd(W_RAW, '0, "R3");
    pins(32'h0); rd(W_RAW, '0, "R3");
    // R4 rising edge
    wr(W_EN, 32'h1); rd(W_EN, 32'h1, "R2");
    pins(32'h1); rd(W_RAW, 32'h1, "R4");
    pins(32'h0); rd(W_RAW, 32'h1, "R4");
    wr(W_ACK, 32'h0); rd(W_RAW, 32'h1, "R8");
    wr(W_ACK, 32'h1); rd(W_RAW, 32'h0, "R8");
    // R5 falling edge
    wr(W_POL, 32'h2);
    pins(32'h2);
    wr(W_EN, 32'h3); rd(W_RAW, 32'h0, "R5");
    pins(32'h0); rd(W_RAW, 32'h2, "R5");
    wr(W_ACK, 32'h2); rd(W_RAW, 32'h0, "R8");
    // R6 both edges
    wr(W_DUAL, 32'h4); wr(W_EN, 32'h7);
    pins(32'h4); rd(W_RAW, 32'h4, "R6");
    wr(W_ACK, 32'h4); rd(W_RAW, 32'h0, "R8");
    pins(32'h0); rd(W_RAW, 32'h4, "R6");
    wr(W_ACK, 32'h4); rd(W_RAW, 32'h0, "R8");
    // R7 level lines: bit3 high, bit4 low
    wr(W_KIND, 32'h18); wr(W_POL, 32'h12); wr(W_EN, 32'h1F);
    rd(W_RAW, 32'h10, "R7");
    wr(W_ACK, 32'hFFFFFFFF); rd(W_RAW, 32'h10, "R7");
    pins(32'h08); rd(W_RAW, 32'h18, "R7");
    pins(32'h18); rd(W_RAW, 32'h08, "R7");
    pins(32'h10); rd(W_RAW, 32'h00, "R7");
    pins(32'h00); rd(W_RAW, 32'h10, "R7");
    // R9 / R10 mask and interrupt
    rd(W_PEND, 32'h10, "R9"); chk_irq(1'b1, "R10");
    wr(W_MSK, 32'h10);
    rd(W_RAW, 32'h10, "R9"); rd(W_PEND, 32'h0, "R9"); chk_irq(1'b0, "R10");
    wr(W_MSK, 32'h0); chk_irq(1'b1, "R10");
    // R8 clear all
    pins(32'h05); rd(W_RAW, 32'h15, "R4");
    wr(W_ACK, 32'hFFFFFFFF); rd(W_RAW, 32'h10, "R8");
    pins(32'h00); rd(W_RAW, 32'h14, "R6");
    wr(W_ACK, 32'h4); rd(W_RAW, 32'h10, "R8");
    // R11 clear and edge in the same cycle
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = W_ACK; reg_wdata = 32'h1; pin_in = 32'h1;
    @(posedge clk); #1;
    reg_we = 1'b0;
    rd(W_RAW, 32'h11, "R11");
    wr(W_ACK, 32'h1); rd(W_RAW, 32'h10, "R8");
    // R3 disable everything
    wr(W_EN, 32'h0); rd(W_RAW, 32'h0, "R3");
    pins(32'h0); rd(W_RAW, 32'h0, "R3");
    chk_irq(1'b0, "R3");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule